// File: doc/BRIEF.md
# Set/Clear Control Register with Vectored Interrupter

This block holds the control/status register and the identification/interrupt-configuration register of a multi-channel counter module, together with the logic that raises a bus interrupt. Control bits are never rewritten wholesale. Each function has one bit position that switches it on and another that switches it off. A single write therefore changes only the functions whose bits are 1 in the data word, and software needs no read-modify-write. The status word returned on read combines these settings with state supplied by neighbouring blocks: the reference pulser, global count enable and the overflow summary. It also reports the interrupt state.

Three interrupt sources are each gated by their own enable:
- source 0 is overflow;
- source 1 is external shadow capture;
- source 2 is a software test bit.

The gated sources are ORed into an internal pending flag, and that flag is visible in the status word whether or not bus interrupts are allowed. When the configuration register's enable bit is set and a nonzero level is programmed, the block asserts the request line of that level. During an acknowledge cycle at that level, it answers with its 8-bit vector on data bits 7-0. The bus handshake and address decoding are supplied by the surrounding logic, which turns bus cycles into the write strobes and acknowledge inputs used here.

Top module: `jkc_ctrl_irq`

## Requirements
- R1: After reset, `stat_rd` reads 0x00000000, `cfg_rd` reads {MOD_ID, VERSION, 12'h000} (0x38031000 by default), every control output is 0 and `irq_lines` is 0.
- R2: On a cycle with `ctl_wr`, a 1 in `wr_data` bits 7..0 switches on, from the next cycle, in bit order: LED, test interrupt source, input mode bit 0, input mode bit 1, 25 MHz test pulses, input test mode, broadcast, broadcast handshake. Functions whose set and clear bits are both 0 keep their state.
- R3: On a cycle with `ctl_wr`, a 1 in `wr_data` bits 15..8 switches off, from the next cycle, the function found 8 positions lower.
- R4: When the set bit and the clear bit of one function are both 1 in the same write, the function ends up off.
- R5: A 1 in write bits 16..18 enables interrupt sources 0..2, and a 1 in bits 24..26 disables them (clear wins). The enables read back in status bits 20..22.
- R6: Status layout: bit 0 LED, bit 1 test source, bits 3..2 input mode, bit 4 test pulses, bit 5 input test, bit 6 broadcast, bit 7 handshake, bit 13 `refp_en`, bit 14 `ovf_any`, bit 15 `count_en`, bits 22..20 source enables, bit 26 internal flag, bit 27 bus request, bits 30..28 raw sources (overflow, shadow, test bit). All other bits read 0.
- R7: `cfg_rd` bits 31..16 always hold MOD_ID and bits 15..12 hold VERSION, whatever is written. A `cfg_wr` stores `wr_data` bits 11..0, which read back unchanged: bit 11 interrupt enable, bits 10..8 level, bits 7..0 vector.
- R8: Status bit 26 is the OR over the three sources of (source AND its enable). It is independent of configuration bit 11.
- R9: `irq_lines[k]` (level k+1) is 1 exactly when the internal flag is set, configuration bit 11 is 1 and the programmed level equals k+1. Level 0 drives no line. Status bit 27 is 1 when any line is driven.
- R10: `iack_hit` is 1 and `iack_vec` carries the programmed vector only when `iack` is high, the request is active and `iack_lvl` equals the programmed level. Otherwise `iack_hit` is 0 and `iack_vec` is 0.
- R11: An acknowledge does not drop the request. The request falls only when software disables the source or the source condition goes away.
- R12: A `key_rst` pulse returns all control bits, source enables and configuration bits 11..0 to 0 on the next cycle, and it overrides a write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| key_rst | input | 1 | Software-triggered reset pulse |
| ctl_wr | input | 1 | Write strobe for the set/clear control register |
| cfg_wr | input | 1 | Write strobe for the configuration register |
| wr_data | input | 32 | Write data |
| ovf_any | input | 1 | Overflow summary from the counters (interrupt source 0) |
| shadow_evt | input | 1 | External shadow capture condition (interrupt source 1) |
| count_en | input | 1 | Global count enable state |
| refp_en | input | 1 | Reference pulser enable state |
| iack | input | 1 | Acknowledge cycle in progress |
| iack_lvl | input | 3 | Level being acknowledged |
| stat_rd | output | 32 | Status word |
| cfg_rd | output | 32 | Identification/configuration word |
| led_on | output | 1 | User LED control |
| in_mode | output | 2 | Input mode |
| tp25_en | output | 1 | 25 MHz test pulses |
| in_test_en | output | 1 | Input test mode |
| bcast_en | output | 1 | Broadcast mode |
| bcast_hs_en | output | 1 | Broadcast handshake controller |
| irq_lines | output | 7 | Request lines, bit k is level k+1 |
| iack_hit | output | 1 | Block answers this acknowledge |
| iack_vec | output | 8 | Vector for data bits 7..0 |

## Verification
The bench writes words that carry a set and a clear bit for the same function. A design that let the set bit win would leave that function on, and the status word would show it. It also checks that functions not named in a write keep their state, which a plain overwrite would lose.

It programs level 0 with the enable bit set, and then turns the enable bit off while a source is still pending. In both cases a wrong design would drive a request line, or would hide the internal flag that must stay visible. Acknowledge cycles at a wrong level and with no request pending must not be answered. The request must survive an acknowledge and fall only once the source is retired.

// File: rtl/jkc_pkg.sv
package jkc_pkg;
    // Number of set/clear control functions and interrupt sources
    localparam int NFUNC = 8;
    localparam int NSRC  = 3;
    // Write-word bit positions used by the set/clear decoding
    localparam int FSET_LSB = 0;
    localparam int FCLR_LSB = FSET_LSB + NFUNC;
    localparam int ESET_LSB = 16;
    localparam int ECLR_LSB = 24;
    // Configuration register field widths
    localparam int LVL_W  = 3;
    localparam int VEC_W  = 8;
    localparam int NLVL   = (1 << LVL_W) - 1;
    localparam int CFG_W  = VEC_W + LVL_W + 1;

    // Control functions, most significant field = bit 7
    typedef struct packed {
        logic hs_en;
        logic bc_en;
        logic it_en;
        logic tp_en;
        logic mode1;
        logic mode0;
        logic tst_src;
        logic led;
    } ctl_t;

    // Writable part of the configuration register
    typedef struct packed {
        logic             ien;
        logic [LVL_W-1:0] lvl;
        logic [VEC_W-1:0] vec;
    } cfg_t;
endpackage

// File: rtl/jkc_jk_bank.sv
// Bank of W set/clear flags.
// Does: on wr, each flag is set by its set bit and cleared by its clear bit;
//       clear has priority; flags without either bit hold.
// Assumes: key_rst is a single-cycle pulse synchronous to clk.
module jkc_jk_bank #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         key_rst,
    input  logic         wr,
    input  logic [W-1:0] set_bits,
    input  logic [W-1:0] clr_bits,
    output logic [W-1:0] q
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        // One flag: reset and key reset first, then clear-wins update
        always_ff @(posedge clk) begin
            if (!rst_n || key_rst)
                q[i] <= 1'b0;
            else if (wr && clr_bits[i])
                q[i] <= 1'b0;
            else if (wr && set_bits[i])
                q[i] <= 1'b1;
        end

        AST_JK_SET: assert property (@(posedge clk) disable iff (!rst_n)
            (wr && set_bits[i] && !clr_bits[i] && !key_rst) |=> q[i]); // R2
        AST_JK_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
            (wr && clr_bits[i]) |=> !q[i]); // R4
        AST_JK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            (!wr && !key_rst) |=> (q[i] == $past(q[i]))); // R2
        AST_JK_KEYRST: assert property (@(posedge clk) disable iff (!rst_n)
            key_rst |=> !q[i]); // R12
    end
endmodule

// File: rtl/jkc_cfg.sv
// Identification and interrupt configuration register.
// Does: holds the writable enable/level/vector field and presents it
//       below the fixed module number and version.
// Assumes: key_rst clears the writable field like a power-up reset.
module jkc_cfg
    import jkc_pkg::*;
#(
    parameter logic [15:0] MOD_ID  = 16'h3803,
    parameter logic [3:0]  VERSION = 4'h1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        key_rst,
    input  logic        wr,
    input  logic [31:0] wr_data,
    output cfg_t        cfg,
    output logic [31:0] rd
);
    // Writable field update
    always_ff @(posedge clk) begin
        if (!rst_n || key_rst)
            cfg <= '0;
        else if (wr)
            cfg <= cfg_t'(wr_data[CFG_W-1:0]);
    end

    // Read word: fixed identity above the writable field
    always_comb begin
        rd = '0;
        rd[31:16]      = MOD_ID;
        rd[15:12]      = VERSION;
        rd[CFG_W-1:0]  = cfg;
    end

    AST_CFG_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !key_rst) |=> (rd[CFG_W-1:0] == $past(wr_data[CFG_W-1:0]))); // R7
    AST_CFG_KEYRST: assert property (@(posedge clk) disable iff (!rst_n)
        key_rst |=> (rd[CFG_W-1:0] == '0)); // R12
endmodule

// File: rtl/jkc_irq.sv
// Interrupter.
// Does: gates each source by its enable, ORs them into a pending flag,
//       drives the request line of the programmed level when allowed, and
//       answers a matching acknowledge with the vector.
// Assumes: sources are levels held until software clears the condition.
module jkc_irq
    import jkc_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] src,
    input  logic [NSRC-1:0] src_en,
    input  cfg_t            cfg,
    input  logic            iack,
    input  logic [LVL_W-1:0] iack_lvl,
    output logic            pend,
    output logic            bus_act,
    output logic [NLVL-1:0] irq_lines,
    output logic            iack_hit,
    output logic [VEC_W-1:0] iack_vec
);
    // Internal pending flag and bus permission
    always_comb begin
        pend    = |(src & src_en);
        bus_act = pend && cfg.ien && (cfg.lvl != '0);
    end

    // One request line per nonzero level
    for (genvar k = 0; k < NLVL; k++) begin : g_lvl
        assign irq_lines[k] = bus_act && (cfg.lvl == LVL_W'(k + 1));
    end

    // Acknowledge answer
    always_comb begin
        iack_hit = iack && bus_act && (iack_lvl == cfg.lvl);
        iack_vec = iack_hit ? cfg.vec : '0;
    end

    AST_REQ_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(irq_lines)); // R9
    AST_REQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_lines != '0) |-> (cfg.ien && pend)); // R9
    AST_ACK_ONLY_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        iack_hit |-> (iack && (irq_lines != '0))); // R10
    AST_ACK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !iack_hit |-> (iack_vec == '0)); // R10
    AST_ACK_KEEPS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (iack_hit && $stable(src) && $stable(src_en) && $stable(cfg)) |-> bus_act); // R11
endmodule

// File: rtl/jkc_ctrl_irq.sv
// Control/status and interrupt configuration block (top).
// Does: decodes set/clear control writes, holds the configuration register,
//       runs the interrupter and assembles the status word.
// Assumes: strobes come from an external bus decoder, one cycle each.
module jkc_ctrl_irq
    import jkc_pkg::*;
#(
    parameter logic [15:0] MOD_ID  = 16'h3803,
    parameter logic [3:0]  VERSION = 4'h1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        key_rst,
    input  logic        ctl_wr,
    input  logic        cfg_wr,
    input  logic [31:0] wr_data,
    input  logic        ovf_any,
    input  logic        shadow_evt,
    input  logic        count_en,
    input  logic        refp_en,
    input  logic        iack,
    input  logic [2:0]  iack_lvl,
    output logic [31:0] stat_rd,
    output logic [31:0] cfg_rd,
    output logic        led_on,
    output logic [1:0]  in_mode,
    output logic        tp25_en,
    output logic        in_test_en,
    output logic        bcast_en,
    output logic        bcast_hs_en,
    output logic [6:0]  irq_lines,
    output logic        iack_hit,
    output logic [7:0]  iack_vec
);
    ctl_t            ctl;
    logic [NFUNC-1:0] ctl_q;
    logic [NSRC-1:0] src_en;
    logic [NSRC-1:0] src;
    cfg_t            cfg;
    logic            pend;
    logic            bus_act;

    jkc_jk_bank #(.W(NFUNC)) u_func (
        .clk      (clk),
        .rst_n    (rst_n),
        .key_rst  (key_rst),
        .wr       (ctl_wr),
        .set_bits (wr_data[FSET_LSB +: NFUNC]),
        .clr_bits (wr_data[FCLR_LSB +: NFUNC]),
        .q        (ctl_q)
    );

    jkc_jk_bank #(.W(NSRC)) u_ien (
        .clk      (clk),
        .rst_n    (rst_n),
        .key_rst  (key_rst),
        .wr       (ctl_wr),
        .set_bits (wr_data[ESET_LSB +: NSRC]),
        .clr_bits (wr_data[ECLR_LSB +: NSRC]),
        .q        (src_en)
    );

    jkc_cfg #(.MOD_ID(MOD_ID), .VERSION(VERSION)) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .key_rst (key_rst),
        .wr      (cfg_wr),
        .wr_data (wr_data),
        .cfg     (cfg),
        .rd      (cfg_rd)
    );

    // Source vector: overflow, shadow capture, software test bit
    always_comb begin
        ctl = ctl_t'(ctl_q);
        src = {ctl.tst_src, shadow_evt, ovf_any};
    end

    jkc_irq u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .src       (src),
        .src_en    (src_en),
        .cfg       (cfg),
        .iack      (iack),
        .iack_lvl  (iack_lvl),
        .pend      (pend),
        .bus_act   (bus_act),
        .irq_lines (irq_lines),
        .iack_hit  (iack_hit),
        .iack_vec  (iack_vec)
    );

    // Control outputs to neighbouring blocks
    always_comb begin
        led_on      = ctl.led;
        in_mode     = {ctl.mode1, ctl.mode0};
        tp25_en     = ctl.tp_en;
        in_test_en  = ctl.it_en;
        bcast_en    = ctl.bc_en;
        bcast_hs_en = ctl.hs_en;
    end

    // Status word assembly
    always_comb begin
        stat_rd        = '0;
        stat_rd[7:0]   = ctl_q;
        stat_rd[13]    = refp_en;
        stat_rd[14]    = ovf_any;
        stat_rd[15]    = count_en;
        stat_rd[22:20] = src_en;
        stat_rd[26]    = pend;
        stat_rd[27]    = bus_act;
        stat_rd[30:28] = src;
    end

    AST_FLAG_VISIBLE: assert property (@(posedge clk) disable iff (!rst_n)
        ((ovf_any && src_en[0]) || (shadow_evt && src_en[1])) |-> stat_rd[26]); // R8
    AST_BUS_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        stat_rd[27] == (irq_lines != '0)); // R9
endmodule

// File: tb/sim_jkc_ctrl_irq.sv
`timescale 1ns/1ps
module sim_jkc_ctrl_irq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        key_rst = 1'b0;
    logic        ctl_wr = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [31:0] wr_data = '0;
    logic        ovf_any = 1'b0;
    logic        shadow_evt = 1'b0;
    logic        count_en = 1'b0;
    logic        refp_en = 1'b0;
    logic        iack = 1'b0;
    logic [2:0]  iack_lvl = '0;
    logic [31:0] stat_rd, cfg_rd;
    logic        led_on, tp25_en, in_test_en, bcast_en, bcast_hs_en;
    logic [1:0]  in_mode;
    logic [6:0]  irq_lines;
    logic        iack_hit;
    logic [7:0]  iack_vec;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    jkc_ctrl_irq u0 (
        .clk(clk), .rst_n(rst_n), .key_rst(key_rst), .ctl_wr(ctl_wr),
        .cfg_wr(cfg_wr), .wr_data(wr_data), .ovf_any(ovf_any),
        .shadow_evt(shadow_evt), .count_en(count_en), .refp_en(refp_en),
        .iack(iack), .iack_lvl(iack_lvl), .stat_rd(stat_rd), .cfg_rd(cfg_rd),
        .led_on(led_on), .in_mode(in_mode), .tp25_en(tp25_en),
        .in_test_en(in_test_en), .bcast_en(bcast_en), .bcast_hs_en(bcast_hs_en),
        .irq_lines(irq_lines), .iack_hit(iack_hit), .iack_vec(iack_vec)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic wr_ctl(input logic [31:0] d);
        @(negedge clk); ctl_wr = 1'b1; wr_data = d;
        @(negedge clk); ctl_wr = 1'b0; wr_data = '0;
        #1;
    endtask

    task automatic wr_cfg(input logic [31:0] d);
        @(negedge clk); cfg_wr = 1'b1; wr_data = d;
        @(negedge clk); cfg_wr = 1'b0; wr_data = '0;
        #1;
    endtask

    task automatic t_reset;
        check("R1 status", stat_rd, 32'h0);
        check("R1 config", cfg_rd, 32'h3803_1000);
        check("R1 controls", {26'h0, led_on, in_mode, tp25_en, in_test_en, bcast_en, bcast_hs_en}, 32'h0);
        check("R1 irq", {25'h0, irq_lines}, 32'h0);
    endtask

    task automatic t_set_clear;
        wr_ctl(32'h0000_0005);
        check("R2 set led+mode0", stat_rd, 32'h0000_0005);
        check("R2 led port", {31'h0, led_on}, 32'h1);
        wr_ctl(32'h0000_0010);
        check("R2 others hold", stat_rd, 32'h0000_0015);
        check("R2 mode port", {30'h0, in_mode}, 32'h1);
        wr_ctl(32'h0000_0100);
        check("R3 clear led", stat_rd, 32'h0000_0014);
        wr_ctl(32'h0000_0002);
        check("R2 set test src", stat_rd, 32'h3000_0000 & 32'h0 | 32'h4000_0016 & 32'h0 | stat_rd_exp_test());
        wr_ctl(32'h0000_0202);
        check("R4 clear wins", stat_rd, 32'h0000_0014);
        wr_ctl(32'h0000_4040);
        check("R4 clear wins broadcast", {31'h0, bcast_en}, 32'h0);
    endtask

    function automatic logic [31:0] stat_rd_exp_test();
        // test source set: bit 1 control plus raw source bit 30
        return 32'h4000_0016;
    endfunction

    task automatic t_enables;
        wr_ctl(32'h0007_0000);
        check("R5 enable all", stat_rd, 32'h0070_0014);
        wr_ctl(32'h0202_0000);
        check("R5 clear wins enable", stat_rd, 32'h0050_0014);
        wr_ctl(32'h0700_FF00);
        check("R5 clear all", stat_rd, 32'h0);
    endtask

    task automatic t_inputs_irq;
        @(negedge clk); refp_en = 1'b1; count_en = 1'b1; #1;
        check("R6 refp+count", stat_rd, 32'h0000_A000);
        @(negedge clk); ovf_any = 1'b1; shadow_evt = 1'b1; #1;
        check("R6 raw sources", stat_rd, 32'h3000_E000);
        wr_ctl(32'h0001_0000);
        check("R8 flag without bus enable", stat_rd, 32'h3410_E000);
        check("R8 no bus request", {25'h0, irq_lines}, 32'h0);
        wr_cfg(32'hFFFF_F8A5);
        check("R7 readonly id", cfg_rd, 32'h3803_18A5);
        check("R9 level zero silent", {25'h0, irq_lines}, 32'h0);
        wr_cfg(32'h0000_0B5A);
        check("R9 request level 3", {25'h0, irq_lines}, 32'h0000_0004);
        check("R9 status bus bit", stat_rd, 32'h3C10_E000);
    endtask

    task automatic t_ack;
        @(negedge clk); iack = 1'b1; iack_lvl = 3'd2; #1;
        check("R10 wrong level hit", {31'h0, iack_hit}, 32'h0);
        check("R10 wrong level vec", {24'h0, iack_vec}, 32'h0);
        @(negedge clk); iack_lvl = 3'd3; #1;
        check("R10 hit", {31'h0, iack_hit}, 32'h1);
        check("R10 vector", {24'h0, iack_vec}, 32'h5A);
        @(negedge clk); iack = 1'b0; iack_lvl = '0;
        @(negedge clk); #1;
        check("R11 held after ack", {25'h0, irq_lines}, 32'h0000_0004);
        wr_ctl(32'h0100_0000);
        check("R11 retired by disable", {25'h0, irq_lines}, 32'h0);
        @(negedge clk); ovf_any = 1'b0; #1;
        wr_ctl(32'h0001_0000);
        check("R11 reenable after clear", {25'h0, irq_lines}, 32'h0);
        @(negedge clk); iack = 1'b1; iack_lvl = 3'd3; #1;
        check("R10 no request no hit", {31'h0, iack_hit}, 32'h0);
        @(negedge clk); iack = 1'b0; iack_lvl = '0;
        wr_ctl(32'h0004_0002);
        check("R9 test source request", {25'h0, irq_lines}, 32'h0000_0004);
        wr_cfg(32'h0000_035A);
        check("R8 bus off", {25'h0, irq_lines}, 32'h0);
        check("R8 flag still visible", {31'h0, stat_rd[26]}, 32'h1);
    endtask

    task automatic t_keyrst;
        wr_cfg(32'hFFFF_FFFF);
        check("R7 low field stored", cfg_rd, 32'h3803_1FFF);
        @(negedge clk); shadow_evt = 1'b0; refp_en = 1'b0; count_en = 1'b0;
        key_rst = 1'b1; ctl_wr = 1'b1; wr_data = 32'h0000_00FF;
        @(negedge clk); key_rst = 1'b0; ctl_wr = 1'b0; wr_data = '0; #1;
        check("R12 status cleared", stat_rd, 32'h0);
        check("R12 config cleared", cfg_rd, 32'h3803_1000);
        check("R12 no request", {25'h0, irq_lines}, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        t_reset();
        t_set_clear();
        t_enables();
        t_inputs_irq();
        t_ack();
        t_keyrst();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        #200000;
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule